// File: doc/BRIEF.md
# External Bus Borrow Arbiter

This block lets an on-chip master borrow a shared external bus that normally belongs to another processor. When the internal master signals that it needs the bus, the block raises a bus request and waits. It waits for the external arbiter to grant the bus while no other agent is acknowledging ownership. It then claims the bus by driving its acknowledge line, and it tells the internal master that the bus is owned.

The bus goes back when the internal master no longer needs it. It also goes back when a halt is in force and the refresh engine has no use for the bus, or when an external master is reaching into the on-chip dual-port memory. All bus pins are active-low. The grant and acknowledge inputs come from another clock domain, so they pass through a synchronizer of `SYNC_STAGES` flops before the state machine uses them. The acknowledge pin is driven only while the bus is owned; at every other time its output enable is off.

Top module: `bus_borrow_arbiter`

## Requirements
- R1: While `rst` is high and on the first edge after it, the block is idle: `bus_req_n_o`=1, `ack_oe_o`=0, `bus_owned_o`=0.
- R2: When idle, a clock edge with `need_bus_i`=1 and no release cause (see R8, R9) moves the block to waiting, and `bus_req_n_o`=0 after that edge. With a release cause present, the block stays idle.
- R3: While waiting, `bus_req_n_o` stays 0. Ownership is taken only when the synchronized grant is asserted (`ext_grant_n_i`=0) and the synchronized acknowledge is negated (`ext_ack_n_i`=1). A grant that arrives while the acknowledge is asserted does not give ownership.
- R4: The grant and acknowledge pins act through `SYNC_STAGES`=2 flops. Ownership appears after the third rising edge that follows the pin change, and not before that edge.
- R5: While owned: `bus_owned_o`=1, `ack_oe_o`=1, `ack_n_o`=0, and `bus_req_n_o`=1.
- R6: Whenever the bus is not owned, `ack_oe_o`=0 and `bus_owned_o`=0.
- R7: When owned, the block stays owned while `need_bus_i`=1 and no release cause is present. It returns to idle one edge after `need_bus_i` falls.
- R8: `halt_i`=1 together with `refresh_need_i`=0 is a release cause: it ends ownership or waiting on the next edge. `halt_i`=1 with `refresh_need_i`=1 is not a release cause.
- R9: `dpram_ext_access_i`=1 is a release cause: it ends ownership or waiting on the next edge.
- R10: While waiting, a clock edge with `need_bus_i`=0 returns the block to idle with `bus_req_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| need_bus_i | input | 1 | Internal master requires the external bus |
| halt_i | input | 1 | Halt in force |
| refresh_need_i | input | 1 | Refresh engine needs the external bus |
| dpram_ext_access_i | input | 1 | External master is accessing dual-port memory |
| ext_grant_n_i | input | 1 | External bus grant, active low, asynchronous |
| ext_ack_n_i | input | 1 | External grant-acknowledge line, active low, asynchronous |
| bus_req_n_o | output | 1 | Bus request, active low |
| ack_n_o | output | 1 | Acknowledge drive value, active low |
| ack_oe_o | output | 1 | Output enable of the acknowledge pin |
| bus_owned_o | output | 1 | Bus is owned by this block |

## Verification
The internal inputs (need, halt, refresh, dual-port access) take effect on the first rising edge after they change. A grant or acknowledge pin change takes effect on the third edge, because it crosses two synchronizer flops before it reaches the state register. The bench drives every input on the falling edge and samples on the next falling edge. Its reference model applies the same two-stage delay to the pin values, so each expectation is computed for the exact edge on which the result is due. The directed checks count edges explicitly to confirm that ownership is absent after the second edge and present after the third.

// File: rtl/bus_borrow_pkg.sv
package bus_borrow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2
  } borrow_state_t;
endpackage

// File: rtl/bus_borrow_sync.sv
module bus_borrow_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/bus_borrow_fsm.sv
module bus_borrow_fsm
  import bus_borrow_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic need_i,
  input  logic halt_i,
  input  logic refresh_need_i,
  input  logic dpram_access_i,
  input  logic grant_s_i,
  input  logic ack_s_i,
  output logic req_o,
  output logic own_o
);
  borrow_state_t state_q, state_d;
  logic release_cause;

  assign release_cause = dpram_access_i | (halt_i & ~refresh_need_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (need_i && !release_cause) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!need_i || release_cause)    state_d = ST_IDLE;
        else if (grant_s_i && !ack_s_i)  state_d = ST_OWN;
      end
      ST_OWN:  if (!need_i || release_cause) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_o   <= 1'b0;
      own_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_o   <= (state_d == ST_WAIT);
      own_o   <= (state_d == ST_OWN);
    end
  end

  assert_req_own_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(req_o && own_o));
  assert_take_needs_free_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (!own_o && state_q == ST_WAIT && !(grant_s_i && !ack_s_i)) |=> !own_o);
  assert_hold_own_R7: assert property (@(posedge clk) disable iff (rst)
    (own_o && need_i && !dpram_access_i && !(halt_i && !refresh_need_i)) |=> own_o);
  assert_halt_release_R8: assert property (@(posedge clk) disable iff (rst)
    (own_o && halt_i && !refresh_need_i) |=> !own_o);
  assert_dpram_release_R9: assert property (@(posedge clk) disable iff (rst)
    dpram_access_i |=> (!own_o && !req_o));
  assert_wait_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (req_o && !need_i) |=> !req_o);
endmodule

// File: rtl/bus_borrow_arbiter.sv
module bus_borrow_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic need_bus_i,
  input  logic halt_i,
  input  logic refresh_need_i,
  input  logic dpram_ext_access_i,
  input  logic ext_grant_n_i,
  input  logic ext_ack_n_i,
  output logic bus_req_n_o,
  output logic ack_n_o,
  output logic ack_oe_o,
  output logic bus_owned_o
);
  localparam int NUM_ASYNC = 2;

  logic [NUM_ASYNC-1:0] pins_hi, pins_s;
  logic req_q, own_q;

  assign pins_hi = {~ext_ack_n_i, ~ext_grant_n_i};

  bus_borrow_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_ASYNC)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pins_hi),
    .sync_o  (pins_s)
  );

  bus_borrow_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .need_i         (need_bus_i),
    .halt_i         (halt_i),
    .refresh_need_i (refresh_need_i),
    .dpram_access_i (dpram_ext_access_i),
    .grant_s_i      (pins_s[0]),
    .ack_s_i        (pins_s[1]),
    .req_o          (req_q),
    .own_o          (own_q)
  );

  assign bus_req_n_o = ~req_q;
  assign ack_n_o     = ~own_q;
  assign ack_oe_o    = own_q;
  assign bus_owned_o = own_q;

  assert_oe_only_owned_R6: assert property (@(posedge clk) disable iff (rst)
    ack_oe_o == bus_owned_o);
  assert_owned_drives_ack_R5: assert property (@(posedge clk) disable iff (rst)
    bus_owned_o |-> (!ack_n_o && bus_req_n_o));
endmodule

// File: tb/bus_borrow_arbiter_test.sv
module bus_borrow_arbiter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic need = 0, halt = 0, rfsh = 0, dpram = 0, gnt_n = 1, ack_n = 1;
  logic req_n, ackd_n, ack_oe, owned;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  bus_borrow_arbiter uut (
    .clk(clk), .rst(rst), .need_bus_i(need), .halt_i(halt),
    .refresh_need_i(rfsh), .dpram_ext_access_i(dpram),
    .ext_grant_n_i(gnt_n), .ext_ack_n_i(ack_n),
    .bus_req_n_o(req_n), .ack_n_o(ackd_n), .ack_oe_o(ack_oe), .bus_owned_o(owned)
  );

  // reference model: 0 idle, 1 waiting, 2 owned
  int m_st = 0;
  logic g1 = 0, g2 = 0, a1 = 0, a2 = 0;

  function automatic int next_st(int st, logic nd, logic h, logic r, logic d, logic g, logic a);
    logic rel;
    rel = d | (h & ~r);
    case (st)
      0: return (nd && !rel) ? 1 : 0;
      1: return (!nd || rel) ? 0 : ((g && !a) ? 2 : 1);
      default: return (!nd || rel) ? 0 : 2;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; g1 = 0; g2 = 0; a1 = 0; a2 = 0;
    end else begin
      m_st = next_st(m_st, need, halt, rfsh, dpram, g2, a2);
      g2 = g1; g1 = ~gnt_n;
      a2 = a1; a1 = ~ack_n;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model(string tag);
    chk({tag, " req_n"},  req_n,  m_st != 1);
    chk({tag, " owned"},  owned,  m_st == 2);
    chk({tag, " oe R6"},  ack_oe, m_st == 2);
    if (m_st == 2) chk({tag, " ack_n R5"}, ackd_n, 1'b0);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    chk("R1 reset req_n", req_n, 1'b1);
    chk("R1 reset oe", ack_oe, 1'b0);
    chk("R1 reset owned", owned, 1'b0);
    rst = 0;
    step(1);
    chk("R1 after reset owned", owned, 1'b0);

    // R2 blocked by dual-port access
    need = 1; dpram = 1; step(1);
    chk("R2 blocked stays idle", req_n, 1'b1);
    dpram = 0; step(1);
    chk("R2 request raised", req_n, 1'b0);

    // R3 grant while ack asserted
    gnt_n = 0; ack_n = 0; step(4);
    chk("R3 no own with ack asserted", owned, 1'b0);
    chk("R3 request held", req_n, 1'b0);

    // R4 ack negated: owned after third edge only
    ack_n = 1; step(2);
    chk("R4 not owned after two edges", owned, 1'b0);
    step(1);
    chk("R4 owned after third edge", owned, 1'b1);
    chk("R5 ack_n driven low", ackd_n, 1'b0);
    chk("R5 request negated", req_n, 1'b1);
    chk("R5 oe on", ack_oe, 1'b1);

    // R8 halt with refresh need keeps; without releases
    halt = 1; rfsh = 1; step(2);
    chk("R8 halt+refresh keeps", owned, 1'b1);
    rfsh = 0; step(1);
    chk("R8 halt release", owned, 1'b0);
    chk("R6 oe off", ack_oe, 1'b0);
    halt = 0; step(1);
    chk("R2 re-request", req_n, 1'b0);
    step(1);
    chk("R7 reacquired", owned, 1'b1);
    step(3);
    chk("R7 stays owned", owned, 1'b1);
    dpram = 1; step(1);
    chk("R9 dpram release", owned, 1'b0);
    dpram = 0; gnt_n = 1; step(1);
    chk("R2 request again", req_n, 1'b0);
    need = 0; step(1);
    chk("R10 wait drop", req_n, 1'b1);
    need = 1; gnt_n = 0; step(5);
    chk("R7 owned before drop", owned, 1'b1);
    need = 0; step(1);
    chk("R7 need drop release", owned, 1'b0);

    // random phase against model
    for (int i = 0; i < 3000; i++) begin
      chk_model("R3 R7 R8 R9 R10 random");
      need  = ($urandom % 8) != 0;
      halt  = ($urandom % 10) == 0;
      rfsh  = $urandom % 2;
      dpram = ($urandom % 16) == 0;
      if ($urandom % 4 == 0) gnt_n = $urandom % 2;
      if ($urandom % 4 == 0) ack_n = ($urandom % 3) == 0;
      step(1);
    end
    chk_model("R4 random final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule